// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital front end of a 12-bit converter that is loaded over a serial link. The link has three inputs: a serial clock, a data line and an active-low select strobe. A fast system clock samples all three. While the strobe is low, each rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. When the strobe returns high, the shift register contents are copied into a holding register, and that register drives the converter code.

The internal shift clock is the serial clock gated by the strobe being low. Because of this gating, a serial clock that is already high when the strobe falls produces one extra shift, and the block reproduces that behaviour. The last stage of the shift register drives a serial output. Several devices can be chained by feeding that output into the next device's data input, with the clock and strobe shared by all of them. One strobe release then updates every device in the chain in the same cycle.

Top module: `dac_serial_loader`

## Requirements
- R1: The shift register is 12 bits wide and receives the code most significant bit first. After exactly 12 shifts, code bit 11 holds the first bit sent and code bit 0 holds the last bit sent.
- R2: A data bit is captured only on a rising edge of the serial clock while the strobe is low. The captured value is the level of the data line at that edge.
- R3: A low-to-high transition of the strobe copies the shift register into `code`, and `update` is high for exactly one system clock cycle, in the cycle in which `code` takes its new value. `code` does not change at any other time.
- R4: While the strobe is high, serial clock edges and data changes have no effect on the shift register.
- R5: If the serial clock is high when the strobe falls, one extra shift takes place at that moment, using the current level of the data line.
- R6: `sdo` always equals bit 11 of the shift register. It changes only on a shift, so a downstream device shifting on the same serial edge takes in the previous bit.
- R7: In a chain of devices with a shared clock and strobe, after 24 bits have been clocked into a pair, the downstream device holds the first 12 bits and the upstream device holds the last 12 bits. Both assert `update` in the same cycle.
- R8: After reset, `code` is 0, `sdo` is 0, `update` is 0 and the shift register is cleared.
- R9: A transfer with more than 12 shifts keeps only the last 12 bits received. A transfer with fewer shifts loads the previous contents shifted left by the number of new bits, with the new bits in the low positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| ld_n | input | 1 | Active-low select; a rising edge loads the holding register |
| sdo | output | 1 | Last shift register stage, for chaining |
| code | output | 12 | Holding register driving the converter |
| update | output | 1 | One-cycle pulse when `code` is loaded |

## Verification
Whole 12-bit frames with distinct bit patterns (alternating, all ones, all zeros, irregular) confirm the bit order and that every position is captured. Overlong and short frames show whether only the last 12 bits survive and whether a partial load keeps the shifted-up earlier contents. A frame that begins with the serial clock already high separates correct gating from an edge detector that ignores the strobe. Toggling the clock while the strobe is high tests the blocking. A second device chained on the serial output confirms both the one-bit hand-off and the simultaneous update.

// File: rtl/dac_serial_loader.sv
module dac_serial_loader #(
  parameter int W    = 12,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck,
  input  logic         sdi,
  input  logic         ld_n,
  output logic         sdo,
  output logic [W-1:0] code,
  output logic         update
);

  logic [SYNC-1:0] sck_q, sdi_q, ld_q;
  logic            sck_s, sdi_s, ld_s;
  logic            gate_q, ld_prev;
  logic            gate, shift_en, load_en;
  logic [W-1:0]    shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sdi_q <= '0;
      ld_q  <= '1;
    end else begin
      sck_q <= {sck_q[SYNC-2:0], sck};
      sdi_q <= {sdi_q[SYNC-2:0], sdi};
      ld_q  <= {ld_q[SYNC-2:0], ld_n};
    end
  end

  assign sck_s    = sck_q[SYNC-1];
  assign sdi_s    = sdi_q[SYNC-1];
  assign ld_s     = ld_q[SYNC-1];
  assign gate     = sck_s & ~ld_s;
  assign shift_en = gate & ~gate_q;
  assign load_en  = ld_s & ~ld_prev;
  assign sdo      = shreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      ld_prev <= 1'b1;
      shreg   <= '0;
      code    <= '0;
      update  <= 1'b0;
    end else begin
      gate_q  <= gate;
      ld_prev <= ld_s;
      update  <= load_en;
      if (shift_en) shreg <= {shreg[W-2:0], sdi_s};
      if (load_en)  code  <= shreg;
    end
  end

endmodule

module dac_serial_loader_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         update,
  input logic [W-1:0] code,
  input logic [W-1:0] shreg,
  input logic         sdo,
  input logic         shift_en,
  input logic         ld_s
);

  AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);  // R3
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !update |-> $stable(code));  // R3
  AST_CODE_FROM_SHREG: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> code == $past(shreg));  // R3
  AST_BLOCKED_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(shreg));  // R4
  AST_SDO_ON_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(shift_en));  // R6
  AST_SDO_LAST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    sdo == shreg[W-1]);  // R6

endmodule

bind dac_serial_loader dac_serial_loader_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .update(update), .code(code), .shreg(shreg),
  .sdo(sdo), .shift_en(shift_en), .ld_s(ld_s)
);

// File: tb/tb_dac_serial_loader.sv
module tb_dac_serial_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, ld_n = 1'b1;
  logic sdo, sdo2, upd, upd2;
  logic [11:0] code, code2;

  int checks = 0, fails = 0;
  logic [11:0] m1 = '0, m2 = '0;
  logic [11:0] q1[$], q2[$];
  string qt[$];
  logic prev_upd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_serial_loader dut (.clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .ld_n(ld_n),
    .sdo(sdo), .code(code), .update(upd));
  dac_serial_loader dut2 (.clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdo), .ld_n(ld_n),
    .sdo(sdo2), .code(code2), .update(upd2));

  task automatic chk(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_model(input logic b);
    m2 = {m2[10:0], m1[11]};
    m1 = {m1[10:0], b};
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    wclk(HALF);
    sck = 1'b1;
    if (!ld_n) shift_model(b);
    wclk(HALF);
    sck = 1'b0;
  endtask

  task automatic release_ld(input string tag);
    wclk(HALF);
    ld_n = 1'b1;
    q1.push_back(m1); q2.push_back(m2); qt.push_back(tag);
    wclk(3 * HALF);
  endtask

  task automatic frame(input logic [23:0] v, input int n, input string tag);
    ld_n = 1'b0;
    wclk(HALF);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    release_ld(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd) begin
        if (q1.size() == 0) chk(1'b0, "R3 unexpected update", code, 12'h000);
        else begin
          string t;
          logic [11:0] e1, e2;
          t = qt.pop_front(); e1 = q1.pop_front(); e2 = q2.pop_front();
          chk(code == e1, {t, " code"}, code, e1);
          chk(code2 == e2, "R7 downstream code", code2, e2);
        end
        chk(!prev_upd, "R3 pulse width", {11'd0, prev_upd}, 12'd0);
      end
      if (upd2 != upd) chk(1'b0, "R7 simultaneous update", {11'd0, upd2}, {11'd0, upd});
      prev_upd <= upd;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wclk(3);
    chk(code == 12'h000, "R8 code reset", code, 12'h000);
    chk(sdo == 1'b0, "R8 sdo reset", {11'd0, sdo}, 12'd0);
    chk(upd == 1'b0, "R8 update reset", {11'd0, upd}, 12'd0);
    rst_n = 1'b1;
    wclk(6);
    chk(code == 12'h000 && upd == 1'b0, "R8 idle after reset", code, 12'h000);

    frame(24'h000A5C, 12, "R1 R2 pattern A5C");
    frame(24'h000FFF, 12, "R2 all ones");
    frame(24'h000000, 12, "R2 all zeros");

    ld_n = 1'b0;
    wclk(HALF);
    for (int i = 11; i >= 7; i--) send_bit(1'b1 ^ i[0]);
    wclk(HALF);
    chk(sdo == m1[11], "R6 sdo mid-frame", {11'd0, sdo}, {11'd0, m1[11]});
    for (int i = 6; i >= 0; i--) send_bit(i[1]);
    wclk(HALF);
    chk(sdo == m1[11], "R6 sdo full frame", {11'd0, sdo}, {11'd0, m1[11]});
    release_ld("R1 irregular pattern");

    for (int i = 0; i < 6; i++) send_bit(i[0]);
    ld_n = 1'b0;
    wclk(2 * HALF);
    release_ld("R4 clocks ignored while high");

    frame(24'h003B7D, 14, "R9 overlong");
    frame(24'h000009, 4, "R9 short");

    sdi = 1'b1;
    wclk(HALF);
    sck = 1'b1;
    wclk(2 * HALF);
    ld_n = 1'b0;
    shift_model(1'b1);
    wclk(HALF);
    sck = 1'b0;
    wclk(HALF);
    for (int i = 10; i >= 0; i--) send_bit(i[0] ^ i[2]);
    release_ld("R5 spurious edge");

    frame(24'hC3A519, 24, "R7 chain upstream");
    frame(24'h123456, 24, "R7 chain second");

    wclk(20);
    chk(q1.size() == 0, "R3 missing updates", 12'(q1.size()), 12'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule